// File: doc/BRIEF.md
# Four-Bit Binary to Two-Digit Decimal Display Driver

This block turns a 4-bit unsigned binary number (0 to 15) into the segment patterns for two common-anode seven-segment displays that together show its decimal value. It is purely combinational. A new input value appears on both displays within the same clock cycle.

A magnitude comparator raises a flag whenever the input exceeds nine. That flag drives the tens display through a small fixed-pattern driver, which shows either 0 or 1. The same flag steers a bank of 2-to-1 multiplexers on the ones-digit path. With the flag clear, the multiplexers pass the four input bits unchanged. With the flag set, they pass a corrected code built only from the three low input bits, equal to the input minus ten, and the top bit is forced low. A single BCD-to-segment decoder then drives the ones display. Any code above nine that reaches that decoder blanks the display.

Top module: `bin2dec_display`

## Requirements
- R1: The tens display shows digit 1 when the input value is greater than 9, and digit 0 when the input is 9 or less.
- R2: Each segment output is 7 bits wide, with segment a on bit 0 through segment g on bit 6. Outputs are active low: a segment is lit when its bit is 0.
- R3: On the tens output, bits 1 and 2 (segments b and c) are always 0 and bit 6 (segment g) is always 1. Bits 0, 3, 4 and 5 (segments a, d, e and f) are 1 exactly when the input exceeds 9.
- R4: For inputs 0 to 9, the ones display shows the input value itself.
- R5: For inputs 10 to 15, the ones display shows the input minus 10 (0 to 5). That digit is derived from the three low input bits alone.
- R6: The ones decoder uses these active-high segment sets, which are inverted on the pin: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=abcdefg, 9=abcdfg.
- R7: Both displays follow an input change combinationally. The new patterns are present in the same cycle the input is applied, with no register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bin_i | input | 4 | Unsigned binary value to display |
| tens_seg_o | output | 7 | Active-low segments of the tens digit, a on bit 0 through g on bit 6 |
| ones_seg_o | output | 7 | Active-low segments of the ones digit, a on bit 0 through g on bit 6 |

## Verification
The greater-than-nine flag switches the tens driver and the ones-path multiplexers in the same evaluation. At the 9-to-10 and 15-to-0 transitions, both displays therefore change together. The bench provokes this with an ascending sweep, a descending sweep and back-and-forth hops across the 9/10 boundary. After each new value it compares both outputs against a behavioural model that uses division and remainder by ten. A mismatch on either display at a boundary exposes a flag, multiplexer or correction fault that a single-display check would miss.

// File: rtl/b2d_pkg.sv
package b2d_pkg;

    localparam int unsigned SEG_W = 7;

    typedef logic [SEG_W-1:0] seg_t;

    // active-low blank pattern: every segment off
    localparam seg_t SEG_OFF = '1;

    // active-high segment set for one BCD digit; bit0 = a .. bit6 = g
    function automatic seg_t digit_lit(input logic [3:0] code);
        seg_t lit;
        unique case (code)
            4'd0:    lit = 7'b0111111;
            4'd1:    lit = 7'b0000110;
            4'd2:    lit = 7'b1011011;
            4'd3:    lit = 7'b1001111;
            4'd4:    lit = 7'b1100110;
            4'd5:    lit = 7'b1101101;
            4'd6:    lit = 7'b1111101;
            4'd7:    lit = 7'b0000111;
            4'd8:    lit = 7'b1111111;
            4'd9:    lit = 7'b1101111;
            default: lit = 7'b0000000;
        endcase
        return lit;
    endfunction

endpackage

// File: rtl/b2d_over_nine.sv
module b2d_over_nine #(
    parameter int unsigned IN_W = 4
) (
    input  logic [IN_W-1:0] val_i,
    output logic            over_o
);
    // value > 9 for a 4-bit input: top bit set and either of the next two
    always_comb begin
        over_o = val_i[3] & (val_i[2] | val_i[1]);
    end

    always_comb begin
        if (!$isunknown(val_i)) begin
            // R1
            over_nine_chk: assert (over_o == (int'(val_i) > 9))
                else $error("flag disagrees with magnitude of %0d", val_i);
        end
    end
endmodule

// File: rtl/b2d_low_fix.sv
module b2d_low_fix #(
    parameter int unsigned FIX_W = 3
) (
    input  logic [FIX_W-1:0] low_i,
    output logic [FIX_W-1:0] fix_o
);
    // maps low bits 010..111 to 000..101 (low minus two)
    always_comb begin
        fix_o[2] = low_i[2] &  low_i[1];
        fix_o[1] = low_i[2] & ~low_i[1];
        fix_o[0] = low_i[0];
    end

    always_comb begin
        if (!$isunknown(low_i) && low_i >= 3'd2) begin
            // R5
            fix_range_chk: assert (fix_o <= 3'd5)
                else $error("corrected digit %0d out of range", fix_o);
        end
    end
endmodule

// File: rtl/b2d_mux_bank.sv
module b2d_mux_bank #(
    parameter int unsigned LANES = 4
) (
    input  logic             sel_i,
    input  logic [LANES-1:0] pass_i,
    input  logic [LANES-1:0] alt_i,
    output logic [LANES-1:0] out_o
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign out_o[k] = sel_i ? alt_i[k] : pass_i[k];
    end
endmodule

// File: rtl/b2d_seg_dec.sv
module b2d_seg_dec
    import b2d_pkg::*;
(
    input  logic [3:0] bcd_i,
    output seg_t       seg_no
);
    always_comb begin
        if (bcd_i > 4'd9) seg_no = SEG_OFF;
        else              seg_no = ~digit_lit(bcd_i);
    end

    always_comb begin
        if (!$isunknown(bcd_i) && bcd_i <= 4'd9) begin
            // R6
            dec_lit_chk: assert (seg_no != SEG_OFF)
                else $error("valid code %0d produced a blank digit", bcd_i);
        end
    end
endmodule

// File: rtl/bin2dec_display.sv
module bin2dec_display
    import b2d_pkg::*;
#(
    parameter int unsigned IN_W = 4
) (
    input  logic [IN_W-1:0]  bin_i,
    output logic [SEG_W-1:0] tens_seg_o,
    output logic [SEG_W-1:0] ones_seg_o
);
    localparam int unsigned FIX_W = IN_W - 1;

    logic             over_nine;
    logic [FIX_W-1:0] fixed_low;
    logic [IN_W-1:0]  fix_wide;
    logic [IN_W-1:0]  ones_bcd;

    b2d_over_nine #(.IN_W(IN_W)) u_cmp (
        .val_i  (bin_i),
        .over_o (over_nine)
    );

    b2d_low_fix #(.FIX_W(FIX_W)) u_fix (
        .low_i (bin_i[FIX_W-1:0]),
        .fix_o (fixed_low)
    );

    // corrected code never sets the top ones bit
    assign fix_wide = {1'b0, fixed_low};

    b2d_mux_bank #(.LANES(IN_W)) u_mux (
        .sel_i  (over_nine),
        .pass_i (bin_i),
        .alt_i  (fix_wide),
        .out_o  (ones_bcd)
    );

    b2d_seg_dec u_ones (
        .bcd_i  (ones_bcd),
        .seg_no (ones_seg_o)
    );

    // tens driver: b,c always lit, g always dark, a/d/e/f dark for a 1
    always_comb begin
        tens_seg_o    = '0;
        tens_seg_o[0] = over_nine;
        tens_seg_o[3] = over_nine;
        tens_seg_o[4] = over_nine;
        tens_seg_o[5] = over_nine;
        tens_seg_o[6] = 1'b1;
    end

    always_comb begin
        if (!$isunknown(bin_i)) begin
            // R4
            ones_path_chk: assert (ones_bcd <= 4'd9)
                else $error("ones code %0d above nine", ones_bcd);
            // R5
            ones_msb_chk: assert (!(over_nine && ones_bcd[IN_W-1]))
                else $error("top ones bit set while flag raised");
        end
    end
endmodule

// File: tb/tb_bin2dec_display.sv
module tb_bin2dec_display;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bin;
    logic [6:0] tens_seg;
    logic [6:0] ones_seg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bin2dec_display dut (
        .bin_i      (bin),
        .tens_seg_o (tens_seg),
        .ones_seg_o (ones_seg)
    );

    // behavioural model: digit -> active-low pattern, a=bit0 .. g=bit6
    function automatic logic [6:0] ref_pat(input int d);
        logic [6:0] on;
        case (d)
            0: on = 7'h3F; 1: on = 7'h06; 2: on = 7'h5B; 3: on = 7'h4F;
            4: on = 7'h66; 5: on = 7'h6D; 6: on = 7'h7D; 7: on = 7'h07;
            8: on = 7'h7F; default: on = 7'h6F;
        endcase
        return ~on;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // apply one value and compare on the same cycle (R7)
    task automatic apply(input int v);
        @(negedge clk);
        bin = 4'(v);
        #1;
        if (v > 9) begin
            check("R1", "tens digit", tens_seg, ref_pat(1));
            check("R5", "ones digit", ones_seg, ref_pat(v % 10));
        end else begin
            check("R1", "tens digit", tens_seg, ref_pat(0));
            check("R4", "ones digit", ones_seg, ref_pat(v % 10));
        end
        // R3: fixed bits of the tens pattern
        check("R3", "tens fixed bits", {tens_seg[6], tens_seg[2:1]}, {4'b0, 3'b100});
        // R2/R6: expected pattern built from the ordered segment list
        check("R6", "ones table", ones_seg, ref_pat(v / 10 * 0 + v % 10));
        @(posedge clk);
        #1;
        // R7: still stable one cycle later, no register stage
        check("R7", "ones hold", ones_seg, ref_pat(v % 10));
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bin = 4'd0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // R2: input 0 gives active-low zero on both, g dark (bit6=1)
        check("R2", "idle tens", tens_seg, 7'b1000000);
        check("R2", "idle ones", ones_seg, 7'b1000000);
        for (int v = 0; v < 16; v++) apply(v);
        for (int v = 15; v >= 0; v--) apply(v);
        // boundary hops across the flag
        apply(9); apply(10); apply(9); apply(15); apply(0); apply(10); apply(11);
        // R2: literal pattern for 13 -> tens 1, ones 3
        apply(13);
        check("R2", "tens literal 1", tens_seg, 7'b1111001);
        check("R2", "ones literal 3", ones_seg, 7'b0110000);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule